// File: doc/BRIEF.md
# Serial Debug Port Frame Interface

This block links an external development tool to a processor core over a bit-serial line. The tool drives a serial clock and a data-in line. Each frame it sends holds 35 bits: a start bit, a mode bit, a control bit and a 32-bit payload. While those bits arrive, the block shifts a reply frame out on the data-out line. The reply carries a ready marker, a 2-bit status code and 32 data bits. Serial clock and data-in are synchronised into the system clock domain, and all state changes on the detected rising edge of the serial clock.

In debug mode the payload goes to the core as an instruction or as data, through a valid/ready handshake. The core's request line is the ready side, and the core also states which kind of word it expects. A frame of the wrong kind is dropped, and a sequence error is reported in the next reply. The core can deposit a read-back word into the port data register. That word is returned with the highest-priority status. A second mode either loads a trap enable register or decodes a 7-bit port command. Each known command gives a one-cycle pulse on its own output.

Top module: `dsp_serial_port`

## Requirements
- R1: A reply frame is shifted out MSB first: a ready bit of 0, then status bit 1, status bit 0, then data bits 31 down to 0. The status codes are 00 valid data, 01 sequence error, 10 interrupt pending and 11 null. For every status other than 00 the data bits are zero. The first bit is on `dbg_sdo` before the start-bit edge, and each rising serial-clock edge advances one bit.
- R2: `dbg_sdo` is high when no frame is armed. A frame is armed only while `core_rd_req` is high, and this is shown by `dbg_sdo` going low.
- R3: An incoming frame begins at the first rising serial-clock edge that samples `dbg_sdi` = 1 while armed. It then takes the mode bit, the control bit and the payload MSB first. Edges that sample 0 before the start bit are ignored. Edges while `dbg_sdo` is high are also ignored.
- R4: Mode 0 is debug mode. When the control bit equals `core_rd_kind` (0 instruction, 1 data), the payload appears on `xfer_word` with a one-cycle `xfer_valid`, and `xfer_is_data` equals the control bit.
- R5: In mode 0, a control bit that differs from `core_rd_kind` discards the payload and gives no `xfer_valid`. The next reply carries status 01. The reply after that no longer reports the error.
- R6: A word accepted on `core_wr_valid` while `core_wr_ready` is high is returned with status 00. Status 00 takes priority over a sequence error and over a pending interrupt. `core_wr_ready` stays low from the accepted write until that word has been shifted out.
- R7: Mode 1 with control 0 writes the low `TRAP_W` payload bits into `trap_en`. `trap_en` changes at no other time.
- R8: Mode 1 with control 1 takes payload bits 31..25 as a command code. Code 0011111 pulses `brk_negate_p`, 0011110 pulses `core_reset_p`, 0011101 pulses `fdl_on_p` and 0011100 pulses `fdl_off_p`, each for one cycle.
- R9: Code 0000000 (no operation) and every other undefined code give no pulse, no transfer and no `trap_en` change. At most one command pulse is high in any cycle.
- R10: After a delivery on `xfer_valid` the port stays idle with `dbg_sdo` high until `core_rd_req` has been seen low.
- R11: Without valid data, a pending sequence error (01) outranks `irq_pend` (10). With neither, the status is 11. The status is sampled at the cycle the start bit is taken.
- R12: A low `rst_n` abandons a partially received frame. It also clears the pending status, the data register flag and `trap_en`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dbg_sclk | input | 1 | Serial clock from the tool |
| dbg_sdi | input | 1 | Serial data in |
| dbg_sdo | output | 1 | Serial data out, high when idle |
| core_rd_req | input | 1 | Core waits for a word (ready side of the handshake) |
| core_rd_kind | input | 1 | Kind expected by the core: 0 instruction, 1 data |
| irq_pend | input | 1 | Interrupt pending flag from the core |
| xfer_valid | output | 1 | One-cycle strobe: word delivered to the core |
| xfer_word | output | 32 | Delivered instruction or data word |
| xfer_is_data | output | 1 | Delivered word is data (1) or instruction (0) |
| core_wr_valid | input | 1 | Core writes a read-back word |
| core_wr_data | input | 32 | Read-back word |
| core_wr_ready | output | 1 | Port data register empty |
| trap_en | output | 32 | Trap enable register |
| brk_negate_p | output | 1 | Pulse: negate breakpoint requests |
| core_reset_p | output | 1 | Pulse: reset the processor |
| fdl_on_p | output | 1 | Pulse: enable fast download |
| fdl_off_p | output | 1 | Pulse: disable fast download |

## Verification
A bit counter that is off by one shows up in the very next frame. The status or data bits come back shifted, or the command code lands in the wrong payload bits and the wrong pulse fires. A stale sequence-error flag or data-full flag shows in the status field of the next reply frame, because every reply is compared with an independent model of the pending flags. A wrong arming decision shows within a few cycles as `dbg_sdo` staying high or dropping when it should not. All 128 command codes are swept, so a single wrong decode entry is reported in the frame that carries it.

// File: rtl/dsp_pkg.sv
package dsp_pkg;

  localparam int CODE_W = 7;

  typedef enum logic [1:0] {
    ST_VALID  = 2'b00,
    ST_SEQERR = 2'b01,
    ST_IRQ    = 2'b10,
    ST_NULL   = 2'b11
  } dsp_status_e;

  typedef enum logic [2:0] {
    CMD_NONE,
    CMD_NEG_BRK,
    CMD_RESET,
    CMD_FDL_ON,
    CMD_FDL_OFF
  } dsp_cmd_e;

  typedef enum logic [1:0] {
    SH_IDLE,
    SH_ARMED,
    SH_SHIFT
  } dsp_shift_e;

  localparam logic [CODE_W-1:0] CODE_NEG_BRK = 7'b0011111;
  localparam logic [CODE_W-1:0] CODE_RESET   = 7'b0011110;
  localparam logic [CODE_W-1:0] CODE_FDL_ON  = 7'b0011101;
  localparam logic [CODE_W-1:0] CODE_FDL_OFF = 7'b0011100;

  // Status priority: returned data, then sequence error, then interrupt.
  function automatic dsp_status_e pick_status(input logic full, input logic seq,
                                              input logic irq);
    if (full) return ST_VALID;
    if (seq)  return ST_SEQERR;
    if (irq)  return ST_IRQ;
    return ST_NULL;
  endfunction

  // Unlisted codes (including the no-operation code) decode to CMD_NONE.
  function automatic dsp_cmd_e decode_cmd(input logic [CODE_W-1:0] code);
    case (code)
      CODE_NEG_BRK: return CMD_NEG_BRK;
      CODE_RESET:   return CMD_RESET;
      CODE_FDL_ON:  return CMD_FDL_ON;
      CODE_FDL_OFF: return CMD_FDL_OFF;
      default:      return CMD_NONE;
    endcase
  endfunction

endpackage

// File: rtl/dsp_sclk_sync.sv
module dsp_sclk_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sclk,
  input  logic sdi,
  output logic sclk_rise,
  output logic sdi_s
);
  logic [STAGES-1:0] sc_q;
  logic [STAGES-1:0] sd_q;
  logic              sc_prev;

  // Both lines pass through chains of equal length, so sdi_s lines up with the edge.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sc_q    <= '0;
      sd_q    <= '0;
      sc_prev <= 1'b0;
    end else begin
      sc_q    <= {sc_q[STAGES-2:0], sclk};
      sd_q    <= {sd_q[STAGES-2:0], sdi};
      sc_prev <= sc_q[STAGES-1];
    end
  end

  assign sclk_rise = sc_q[STAGES-1] & ~sc_prev;
  assign sdi_s     = sd_q[STAGES-1];

  p_rise_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
    sclk_rise |=> !sclk_rise);

endmodule

// File: rtl/dsp_frame_shifter.sv
module dsp_frame_shifter
  import dsp_pkg::*;
#(
  parameter int PAYLOAD_W = 32
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   sclk_rise,
  input  logic                   sdi_s,
  input  logic                   arm_ok,
  input  dsp_status_e            load_status,
  input  logic [PAYLOAD_W-1:0]   load_data,
  output logic                   sdo,
  output logic                   frame_done,
  output logic [PAYLOAD_W+1:0]   rx_body,
  output dsp_status_e            sent_status,
  output logic                   load_evt
);
  localparam int FRAME_W = PAYLOAD_W + 3;
  localparam int BODY_W  = FRAME_W - 1;
  localparam int CNT_W   = $clog2(FRAME_W);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(FRAME_W - 1);

  dsp_shift_e          state;
  logic [BODY_W-1:0]   rx_sr;
  logic [FRAME_W-1:0]  tx_sr;
  logic [CNT_W-1:0]    bit_cnt;
  logic                start_seen;

  assign start_seen = (state == SH_ARMED) && sclk_rise && sdi_s;
  // The reply is reloaded every cycle until the start bit is taken.
  assign load_evt   = ((state == SH_IDLE) && arm_ok) ||
                      ((state == SH_ARMED) && !start_seen);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state       <= SH_IDLE;
      rx_sr       <= '0;
      tx_sr       <= '1;
      bit_cnt     <= '0;
      frame_done  <= 1'b0;
      sent_status <= ST_NULL;
    end else begin
      frame_done <= 1'b0;
      if (load_evt) begin
        tx_sr       <= {1'b0, load_status, load_data};
        sent_status <= load_status;
      end
      case (state)
        SH_IDLE: begin
          if (arm_ok) state <= SH_ARMED;
        end
        SH_ARMED: begin
          if (start_seen) begin
            rx_sr   <= '0;
            tx_sr   <= {tx_sr[FRAME_W-2:0], 1'b1};
            bit_cnt <= CNT_W'(1);
            state   <= SH_SHIFT;
          end
        end
        SH_SHIFT: begin
          if (sclk_rise) begin
            rx_sr <= {rx_sr[BODY_W-2:0], sdi_s};
            tx_sr <= {tx_sr[FRAME_W-2:0], 1'b1};
            if (bit_cnt == LAST) begin
              state      <= SH_IDLE;
              frame_done <= 1'b1;
            end else begin
              bit_cnt <= bit_cnt + 1'b1;
            end
          end
        end
        default: state <= SH_IDLE;
      endcase
    end
  end

  assign sdo     = (state == SH_IDLE) ? 1'b1 : tx_sr[FRAME_W-1];
  assign rx_body = rx_sr;

  p_ready_low_at_start_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (state == SH_SHIFT && $past(state) == SH_ARMED) |-> $past(sdo) == 1'b0);

  p_done_on_edge_r3: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |-> $past(sclk_rise));

  p_idle_after_done_r2: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |-> sdo);

endmodule

// File: rtl/dsp_frame_decode.sv
module dsp_frame_decode
  import dsp_pkg::*;
#(
  parameter int PAYLOAD_W = 32,
  parameter int TRAP_W    = 32
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  frame_done,
  input  logic [PAYLOAD_W+1:0]  rx_body,
  input  logic                  core_kind,
  output logic                  deliver_now,
  output logic                  seq_set,
  output logic                  xfer_valid,
  output logic [PAYLOAD_W-1:0]  xfer_word,
  output logic                  xfer_is_data,
  output logic [TRAP_W-1:0]     trap_en,
  output logic                  brk_negate_p,
  output logic                  core_reset_p,
  output logic                  fdl_on_p,
  output logic                  fdl_off_p
);
  logic                  mode_bit;
  logic                  ctrl_bit;
  logic [PAYLOAD_W-1:0]  payload;
  logic                  dbg_frame;
  logic                  trap_wr;
  dsp_cmd_e              cmd;

  assign mode_bit    = rx_body[PAYLOAD_W+1];
  assign ctrl_bit    = rx_body[PAYLOAD_W];
  assign payload     = rx_body[PAYLOAD_W-1:0];
  assign dbg_frame   = frame_done && !mode_bit;
  assign deliver_now = dbg_frame && (ctrl_bit == core_kind);
  assign seq_set     = dbg_frame && (ctrl_bit != core_kind);
  assign trap_wr     = frame_done && mode_bit && !ctrl_bit;
  assign cmd         = (frame_done && mode_bit && ctrl_bit)
                       ? decode_cmd(payload[PAYLOAD_W-1 -: CODE_W]) : CMD_NONE;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      xfer_valid   <= 1'b0;
      xfer_word    <= '0;
      xfer_is_data <= 1'b0;
      trap_en      <= '0;
      brk_negate_p <= 1'b0;
      core_reset_p <= 1'b0;
      fdl_on_p     <= 1'b0;
      fdl_off_p    <= 1'b0;
    end else begin
      xfer_valid   <= deliver_now;
      if (deliver_now) begin
        xfer_word    <= payload;
        xfer_is_data <= ctrl_bit;
      end
      if (trap_wr) trap_en <= payload[TRAP_W-1:0];
      brk_negate_p <= (cmd == CMD_NEG_BRK);
      core_reset_p <= (cmd == CMD_RESET);
      fdl_on_p     <= (cmd == CMD_FDL_ON);
      fdl_off_p    <= (cmd == CMD_FDL_OFF);
    end
  end

  p_cmd_onehot_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({brk_negate_p, core_reset_p, fdl_on_p, fdl_off_p}));

  p_seq_drops_word_r5: assert property (@(posedge clk) disable iff (!rst_n)
    seq_set |=> !xfer_valid);

  p_trap_only_on_write_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !trap_wr |=> $stable(trap_en));

  p_pulse_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (brk_negate_p || core_reset_p || fdl_on_p || fdl_off_p) |=>
      !(brk_negate_p || core_reset_p || fdl_on_p || fdl_off_p));

endmodule

// File: rtl/dsp_serial_port.sv
module dsp_serial_port
  import dsp_pkg::*;
#(
  parameter int PAYLOAD_W   = 32,
  parameter int TRAP_W      = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  dbg_sclk,
  input  logic                  dbg_sdi,
  output logic                  dbg_sdo,
  input  logic                  core_rd_req,
  input  logic                  core_rd_kind,
  input  logic                  irq_pend,
  output logic                  xfer_valid,
  output logic [PAYLOAD_W-1:0]  xfer_word,
  output logic                  xfer_is_data,
  input  logic                  core_wr_valid,
  input  logic [PAYLOAD_W-1:0]  core_wr_data,
  output logic                  core_wr_ready,
  output logic [TRAP_W-1:0]     trap_en,
  output logic                  brk_negate_p,
  output logic                  core_reset_p,
  output logic                  fdl_on_p,
  output logic                  fdl_off_p
);
  logic                  sclk_rise;
  logic                  sdi_s;
  logic                  frame_done;
  logic [PAYLOAD_W+1:0]  rx_body;
  dsp_status_e           sent_status;
  dsp_status_e           load_status;
  logic [PAYLOAD_W-1:0]  load_data;
  logic                  load_evt;
  logic                  arm_ok;
  logic                  deliver_now;
  logic                  seq_set;
  logic                  wr_accept;

  logic [PAYLOAD_W-1:0]  pdr;
  logic                  data_full;
  logic                  seq_err;
  logic                  wait_drop;

  dsp_sclk_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk       (clk),
    .rst_n     (rst_n),
    .sclk      (dbg_sclk),
    .sdi       (dbg_sdi),
    .sclk_rise (sclk_rise),
    .sdi_s     (sdi_s)
  );

  assign load_status = pick_status(data_full, seq_err, irq_pend);
  assign load_data   = data_full ? pdr : '0;
  assign arm_ok      = core_rd_req && !wait_drop && !frame_done;

  dsp_frame_shifter #(.PAYLOAD_W(PAYLOAD_W)) u_shift (
    .clk         (clk),
    .rst_n       (rst_n),
    .sclk_rise   (sclk_rise),
    .sdi_s       (sdi_s),
    .arm_ok      (arm_ok),
    .load_status (load_status),
    .load_data   (load_data),
    .sdo         (dbg_sdo),
    .frame_done  (frame_done),
    .rx_body     (rx_body),
    .sent_status (sent_status),
    .load_evt    (load_evt)
  );

  dsp_frame_decode #(.PAYLOAD_W(PAYLOAD_W), .TRAP_W(TRAP_W)) u_dec (
    .clk          (clk),
    .rst_n        (rst_n),
    .frame_done   (frame_done),
    .rx_body      (rx_body),
    .core_kind    (core_rd_kind),
    .deliver_now  (deliver_now),
    .seq_set      (seq_set),
    .xfer_valid   (xfer_valid),
    .xfer_word    (xfer_word),
    .xfer_is_data (xfer_is_data),
    .trap_en      (trap_en),
    .brk_negate_p (brk_negate_p),
    .core_reset_p (core_reset_p),
    .fdl_on_p     (fdl_on_p),
    .fdl_off_p    (fdl_off_p)
  );

  assign core_wr_ready = !data_full;
  assign wr_accept     = core_wr_valid && !data_full;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pdr       <= '0;
      data_full <= 1'b0;
      seq_err   <= 1'b0;
      wait_drop <= 1'b0;
    end else begin
      if (wr_accept) begin
        pdr       <= core_wr_data;
        data_full <= 1'b1;
      end else if (frame_done && sent_status == ST_VALID) begin
        data_full <= 1'b0;
      end
      if (seq_set) seq_err <= 1'b1;
      else if (frame_done && sent_status == ST_SEQERR) seq_err <= 1'b0;
      if (deliver_now) wait_drop <= 1'b1;
      else if (!core_rd_req) wait_drop <= 1'b0;
    end
  end

  p_wr_fills_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (core_wr_valid && core_wr_ready) |=> !core_wr_ready);

  p_valid_first_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (load_evt && data_full) |=> sent_status == ST_VALID);

  p_hold_after_xfer_r10: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_valid |-> (dbg_sdo && $past(dbg_sdo)));

  p_seq_reported_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (load_evt && seq_err && !data_full) |=> sent_status == ST_SEQERR);

endmodule

// File: tb/dsp_serial_port_tb.sv
module dsp_serial_port_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        dbg_sclk = 1'b0;
  logic        dbg_sdi = 1'b0;
  logic        dbg_sdo;
  logic        core_rd_req = 1'b0;
  logic        core_rd_kind = 1'b0;
  logic        irq_pend = 1'b0;
  logic        xfer_valid;
  logic [31:0] xfer_word;
  logic        xfer_is_data;
  logic        core_wr_valid = 1'b0;
  logic [31:0] core_wr_data = '0;
  logic        core_wr_ready;
  logic [31:0] trap_en;
  logic        brk_negate_p, core_reset_p, fdl_on_p, fdl_off_p;

  always #10 clk = ~clk;

  dsp_serial_port u_dut (
    .clk(clk), .rst_n(rst_n), .dbg_sclk(dbg_sclk), .dbg_sdi(dbg_sdi),
    .dbg_sdo(dbg_sdo), .core_rd_req(core_rd_req), .core_rd_kind(core_rd_kind),
    .irq_pend(irq_pend), .xfer_valid(xfer_valid), .xfer_word(xfer_word),
    .xfer_is_data(xfer_is_data), .core_wr_valid(core_wr_valid),
    .core_wr_data(core_wr_data), .core_wr_ready(core_wr_ready), .trap_en(trap_en),
    .brk_negate_p(brk_negate_p), .core_reset_p(core_reset_p),
    .fdl_on_p(fdl_on_p), .fdl_off_p(fdl_off_p)
  );

  int errors = 0;
  int checks = 0;
  int n_brk = 0, n_rst = 0, n_on = 0, n_off = 0, n_xfer = 0;
  logic [31:0] last_word = '0;
  logic        last_is_data = 1'b0;

  always @(posedge clk) begin
    if (rst_n) begin
      if (brk_negate_p) n_brk++;
      if (core_reset_p) n_rst++;
      if (fdl_on_p)     n_on++;
      if (fdl_off_p)    n_off++;
      if (xfer_valid) begin
        n_xfer++;
        last_word    = xfer_word;
        last_is_data = xfer_is_data;
      end
    end
  end

  // Independent model of what the next reply must carry.
  logic        m_full = 1'b0;
  logic [31:0] m_data = '0;
  logic        m_seq = 1'b0;
  logic [31:0] m_trap = '0;
  int e_brk = 0, e_rst = 0, e_on = 0, e_off = 0, e_xfer = 0;

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic run_frame(input logic m, input logic c, input logic [31:0] pl,
                           input int lead, input string tag);
    logic [34:0] tx;
    logic [34:0] rx;
    logic [1:0]  e_st;
    logic [31:0] e_dat;
    int guard;
    tx = {1'b1, m, c, pl};
    guard = 0;
    while (dbg_sdo !== 1'b0 && guard < 400) begin
      @(negedge clk);
      guard++;
    end
    chk({tag, " R2 port armed"}, 64'(dbg_sdo), 64'(0));
    // Status in force when the start bit is taken (R11 order).
    if (m_full)        begin e_st = 2'b00; e_dat = m_data; end
    else if (m_seq)    begin e_st = 2'b01; e_dat = '0; end
    else if (irq_pend) begin e_st = 2'b10; e_dat = '0; end
    else               begin e_st = 2'b11; e_dat = '0; end
    for (int k = 0; k < lead; k++) begin
      dbg_sdi = 1'b0;
      repeat (2) @(negedge clk);
      dbg_sclk = 1'b1; repeat (4) @(negedge clk);
      dbg_sclk = 1'b0; repeat (2) @(negedge clk);
    end
    for (int i = 34; i >= 0; i--) begin
      dbg_sdi = tx[i];
      repeat (2) @(negedge clk);
      rx[i] = dbg_sdo;
      dbg_sclk = 1'b1; repeat (4) @(negedge clk);
      dbg_sclk = 1'b0; repeat (2) @(negedge clk);
    end
    dbg_sdi = 1'b0;
    repeat (6) @(negedge clk);
    chk({tag, " R1 ready bit"}, 64'(rx[34]), 64'(0));
    chk({tag, " R1/R11 status"}, 64'(rx[33:32]), 64'(e_st));
    chk({tag, " R1/R6 data"}, 64'(rx[31:0]), 64'(e_dat));
    if (e_st == 2'b00) m_full = 1'b0;
    if (e_st == 2'b01) m_seq = 1'b0;
    if (!m) begin
      if (c == core_rd_kind) begin
        e_xfer++;
        chk({tag, " R4 transfer count"}, 64'(n_xfer), 64'(e_xfer));
        chk({tag, " R4 word"}, 64'(last_word), 64'(pl));
        chk({tag, " R4 kind"}, 64'(last_is_data), 64'(c));
        chk({tag, " R10 idle until request drops"}, 64'(dbg_sdo), 64'(1));
        core_rd_req = 1'b0;
        repeat (3) @(negedge clk);
        core_rd_req = 1'b1;
      end else begin
        m_seq = 1'b1;
        chk({tag, " R5 no transfer"}, 64'(n_xfer), 64'(e_xfer));
      end
    end else if (!c) begin
      m_trap = pl;
    end else begin
      case (pl[31:25])
        7'b0011111: e_brk++;
        7'b0011110: e_rst++;
        7'b0011101: e_on++;
        7'b0011100: e_off++;
        default: ;
      endcase
    end
    chk({tag, " R7 trap register"}, 64'(trap_en), 64'(m_trap));
    chk({tag, " R8/R9 pulse counts"}, {16'(n_brk), 16'(n_rst), 16'(n_on), 16'(n_off)},
        {16'(e_brk), 16'(e_rst), 16'(e_on), 16'(e_off)});
  endtask

  task automatic core_write(input logic [31:0] d);
    chk("R6 write ready before", 64'(core_wr_ready), 64'(1));
    core_wr_valid = 1'b1;
    core_wr_data  = d;
    @(negedge clk);
    core_wr_valid = 1'b0;
    @(negedge clk);
    chk("R6 write ready held low", 64'(core_wr_ready), 64'(0));
    m_full = 1'b1;
    m_data = d;
  endtask

  localparam int WATCH_CYCLES = 190000;
  bit finished = 1'b0;

  initial begin
    repeat (WATCH_CYCLES) @(posedge clk);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // Reset state (R2, R6, R7)
    chk("R2 idle high after reset", 64'(dbg_sdo), 64'(1));
    chk("R6 register empty after reset", 64'(core_wr_ready), 64'(1));
    chk("R7 trap cleared after reset", 64'(trap_en), 64'(0));

    // R3: edges while not armed are ignored
    for (int k = 0; k < 40; k++) begin
      dbg_sdi = 1'b1;
      repeat (2) @(negedge clk);
      dbg_sclk = 1'b1; repeat (4) @(negedge clk);
      dbg_sclk = 1'b0; repeat (2) @(negedge clk);
    end
    chk("R3 unarmed edges ignored: still idle", 64'(dbg_sdo), 64'(1));
    chk("R3 unarmed edges ignored: no transfer", 64'(n_xfer), 64'(0));

    // R4 basic instruction and data delivery, R3 leading zeros skipped
    core_rd_req = 1'b1;
    core_rd_kind = 1'b0;
    run_frame(1'b0, 1'b0, 32'h1234_5678, 3, "instr");
    core_rd_kind = 1'b1;
    run_frame(1'b0, 1'b1, 32'hCAFE_0001, 0, "data");

    // R4/R5 sweep over expected kind, control bit and payloads
    for (int kd = 0; kd < 2; kd++)
      for (int cb = 0; cb < 2; cb++)
        for (int p = 0; p < 3; p++) begin
          core_rd_kind = kd[0];
          run_frame(1'b0, cb[0], 32'h9E37_79B9 * (p + 1) + 32'(kd * 7 + cb), p,
                    "sweep R5");
          run_frame(1'b1, 1'b1, 32'h0, 0, "sweep follow R5");
        end

    // R6 valid data, R11 priorities
    core_write(32'hDEAD_BEEF);
    run_frame(1'b1, 1'b1, 32'h0, 0, "valid R6");
    chk("R6 register free after report", 64'(core_wr_ready), 64'(1));
    irq_pend = 1'b1;
    run_frame(1'b1, 1'b1, 32'h0, 0, "irq R11");
    core_rd_kind = 1'b0;
    run_frame(1'b0, 1'b1, 32'h5555_AAAA, 0, "mismatch R5");
    core_write(32'h0BAD_F00D);
    run_frame(1'b1, 1'b1, 32'h0, 0, "data over seq R6");
    run_frame(1'b1, 1'b1, 32'h0, 0, "seq over irq R11");
    run_frame(1'b1, 1'b1, 32'h0, 0, "irq after seq R11");
    irq_pend = 1'b0;

    // R7 trap enable loads
    run_frame(1'b1, 1'b0, 32'hA5A5_0F0F, 0, "trap R7");
    run_frame(1'b1, 1'b0, 32'h0000_8001, 1, "trap2 R7");

    // R8/R9 every command code
    for (int code = 0; code < 128; code++)
      run_frame(1'b1, 1'b1, {7'(code), 25'h1ABCDEF}, 0, "cmd R8 R9");
    chk("R8 each command once (brk)", 64'(n_brk), 64'(1));
    chk("R8 each command once (reset)", 64'(n_rst), 64'(1));
    chk("R8 each command once (fdl on)", 64'(n_on), 64'(1));
    chk("R9 reserved codes: no transfer", 64'(n_xfer), 64'(e_xfer));

    // R12 reset abandons a partial frame
    while (dbg_sdo !== 1'b0) @(negedge clk);
    begin
      logic [34:0] part;
      part = {1'b1, 1'b1, 1'b1, 7'b0011110, 25'h0};
      for (int i = 34; i >= 25; i--) begin
        dbg_sdi = part[i];
        repeat (2) @(negedge clk);
        dbg_sclk = 1'b1; repeat (4) @(negedge clk);
        dbg_sclk = 1'b0; repeat (2) @(negedge clk);
      end
    end
    core_write(32'h7777_1111);
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    m_full = 1'b0; m_seq = 1'b0; m_trap = '0;
    repeat (2) @(negedge clk);
    chk("R12 trap cleared", 64'(trap_en), 64'(0));
    chk("R12 data flag cleared", 64'(core_wr_ready), 64'(1));
    chk("R12 no command from partial frame", 64'(n_rst), 64'(e_rst));
    core_rd_kind = 1'b1;
    run_frame(1'b0, 1'b1, 32'h3141_5926, 0, "after reset R12");

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule